// File: doc/BRIEF.md
# SPI Register-Access Snoop Decoder

This block listens, without ever driving, on a four-wire SPI bus (serial clock, controller-out data, controller-in data, active-low chip select) and turns each register-access transaction aimed at one device into a single decoded record. Every bus line is first brought into the system clock domain through a chain of synchronising flops. All edge detection happens on those synchronised copies.

A capture opens when the watched chip select goes low. From then on, both data lines are sampled on each rising serial-clock edge, most significant bit first. The first byte seen on the controller-out line is the command. Its bit 6 is the direction (1 = write, 0 = read) and bits 5..0 are the register address. The second byte is the payload. It is taken from the controller-out line for a write and from the controller-in line for a read. When chip select returns high after a full 16-bit frame, the block presents direction, address and data with a one-cycle valid strobe. If the frame was cut short, the block raises a one-cycle error pulse instead. Serial traffic while the watched chip select is high belongs to other devices and leaves no trace.

Top module: `spi_snoop`

## Requirements
- R1: After reset, `recValid` and `frameErr` are both low and stay low until a framed transaction ends.
- R2: A frame whose command bit 6 is 1 yields a record with `recRw`=1, `recAddr` = command bits 5..0, and `recData` = the second byte shifted in on `spiMosi`.
- R3: A frame whose command bit 6 is 0 yields a record with `recRw`=0, `recAddr` = command bits 5..0, and `recData` = the second byte shifted in on `spiMiso`; the second byte on `spiMosi` has no effect on the record.
- R4: Command bit 7 has no effect on direction, address or data.
- R5: Both data lines are sampled on the rising edge of `spiSclk` while chip select is low, and each byte arrives most significant bit first.
- R6: Serial clock and data activity while `spiCsN` is high produces no record and no error pulse, and does not alter the record of the next framed transaction.
- R7: If `spiCsN` rises after fewer than 16 rising `spiSclk` edges in the frame (including zero), `frameErr` pulses high for exactly one cycle and no record is produced.
- R8: `recValid` is high for exactly one cycle per complete frame, at most 4 system clocks after `spiCsN` rises, and never in the same cycle as `frameErr`.
- R9: Rising `spiSclk` edges beyond the 16th within one frame are ignored: the record reflects the first 16 bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Observed serial clock |
| spiMosi | input | 1 | Observed controller-out data line |
| spiMiso | input | 1 | Observed controller-in data line |
| spiCsN | input | 1 | Observed active-low chip select of the watched device |
| recValid | output | 1 | One-cycle strobe: a decoded record is present |
| recRw | output | 1 | Record direction, 1 = write, 0 = read |
| recAddr | output | 6 | Record register address |
| recData | output | 8 | Record payload byte |
| frameErr | output | 1 | One-cycle pulse: a frame ended before 16 bits |

## Verification
A bit counter that is off by one shows up as a shifted or mis-bucketed payload. In the worst case it turns a good frame into an error pulse, or a short frame into a record. All of these appear at the output within four system clocks of chip select rising. A capture state that fails to return to idle would let traffic on the shared lines leak into the next record, so frames on other chip selects are placed directly before checked frames. A wrong data-line choice is visible only when the two lines carry different second bytes, so every frame drives distinct patterns on both lines.

// File: rtl/spi_snoop_pkg.sv
package spi_snoop_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;   // new frame: empty the shifters
    logic shift;   // take one bit from each data line
    logic emit;    // complete frame: latch a record
    logic abort;   // short frame: drop it
  } snoopStrobe_t;

endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= {STAGES{RESET_VAL}};
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import spi_snoop_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csNSync,
  input  logic         sclkSync,
  output snoopStrobe_t strobe,
  output logic         frameErr
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  typedef enum logic {IDLE, CAPTURE} snoopState_t;

  snoopState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic csPrev, sclkPrev;
  logic csFall, csRise, sclkRise;

  assign csFall   = csPrev & ~csNSync;
  assign csRise   = ~csPrev & csNSync;
  assign sclkRise = ~sclkPrev & sclkSync;

  always_comb begin
    strobe = '0;
    if (state == IDLE) begin
      strobe.clear = csFall;
    end else if (csRise) begin
      strobe.emit  = (bitCnt == FULL);
      strobe.abort = (bitCnt != FULL);
    end else if (sclkRise && bitCnt < FULL) begin
      strobe.shift = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= IDLE;
      bitCnt   <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      csPrev   <= csNSync;
      sclkPrev <= sclkSync;
      frameErr <= strobe.abort;
      if (strobe.clear) begin
        state  <= CAPTURE;
        bitCnt <= '0;
      end else if (strobe.emit || strobe.abort) begin
        state <= IDLE;
      end else if (strobe.shift) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R9: counter saturates at one frame
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);

  // R7: error is a single-cycle pulse
  a_r7_err_single: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  // R6: no bits are counted while the watched select is idle
  a_r6_idle_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (state == IDLE && !csFall) |=> $stable(bitCnt));
endmodule

// File: rtl/snoop_datapath.sv
module snoop_datapath
  import spi_snoop_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 8,
  parameter int ADDR_BITS = 6,
  parameter int RW_POS    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  snoopStrobe_t         strobe,
  input  logic                 mosiSync,
  input  logic                 misoSync,
  output logic                 recValid,
  output logic                 recRw,
  output logic [ADDR_BITS-1:0] recAddr,
  output logic [DATA_BITS-1:0] recData
);
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;

  logic [FRAME_BITS-1:0] mosiSh;
  logic [DATA_BITS-1:0]  misoSh;
  logic [CMD_BITS-1:0]   cmdByte;
  logic                  isWrite;

  assign cmdByte = mosiSh[FRAME_BITS-1 -: CMD_BITS];
  assign isWrite = cmdByte[RW_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosiSh <= '0;
      misoSh <= '0;
    end else if (strobe.clear) begin
      mosiSh <= '0;
      misoSh <= '0;
    end else if (strobe.shift) begin
      mosiSh <= {mosiSh[FRAME_BITS-2:0], mosiSync};
      misoSh <= {misoSh[DATA_BITS-2:0], misoSync};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recValid <= 1'b0;
      recRw    <= 1'b0;
      recAddr  <= '0;
      recData  <= '0;
    end else begin
      recValid <= strobe.emit;
      if (strobe.emit) begin
        recRw   <= isWrite;
        recAddr <= cmdByte[ADDR_BITS-1:0];
        recData <= isWrite ? mosiSh[DATA_BITS-1:0] : misoSh;
      end
    end
  end

  // R8: a record is presented for one cycle only
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);

  // R8: record fields hold steady while no new record is latched
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(recAddr) && $stable(recData) && $stable(recRw));
endmodule

// File: rtl/spi_snoop.sv
module spi_snoop
  import spi_snoop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_BITS    = 8,
  parameter int DATA_BITS   = 8,
  parameter int ADDR_BITS   = 6,
  parameter int RW_POS      = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 spiSclk,
  input  logic                 spiMosi,
  input  logic                 spiMiso,
  input  logic                 spiCsN,
  output logic                 recValid,
  output logic                 recRw,
  output logic [ADDR_BITS-1:0] recAddr,
  output logic [DATA_BITS-1:0] recData,
  output logic                 frameErr
);
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;

  logic [3:0] busSync;
  logic csNSync, sclkSync, mosiSync, misoSync;
  snoopStrobe_t strobe;

  snoop_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b1000)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({spiCsN, spiSclk, spiMosi, spiMiso}),
    .dout(busSync)
  );

  assign {csNSync, sclkSync, mosiSync, misoSync} = busSync;

  snoop_ctrl #(.FRAME_BITS(FRAME_BITS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .csNSync (csNSync),
    .sclkSync(sclkSync),
    .strobe  (strobe),
    .frameErr(frameErr)
  );

  snoop_datapath #(
    .CMD_BITS (CMD_BITS),
    .DATA_BITS(DATA_BITS),
    .ADDR_BITS(ADDR_BITS),
    .RW_POS   (RW_POS)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mosiSync(mosiSync),
    .misoSync(misoSync),
    .recValid(recValid),
    .recRw   (recRw),
    .recAddr (recAddr),
    .recData (recData)
  );

  // R8: record and error never coincide
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(recValid && frameErr));

  // R6: a record only follows a released chip select
  a_r6_after_release: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> $past(csNSync));
endmodule

// File: tb/tb_spi_snoop.sv
module tb_spi_snoop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiMosi = 1'b0, spiMiso = 1'b0, spiCsN = 1'b1;
  logic recValid, recRw, frameErr;
  logic [5:0] recAddr;
  logic [7:0] recData;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  int csRiseCycle = 0;
  bit finished = 1'b0;

  typedef struct {
    bit err;
    bit rw;
    bit [5:0] addr;
    bit [7:0] data;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  spi_snoop dut (
    .clk(clk), .rstN(rstN),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN),
    .recValid(recValid), .recRw(recRw), .recAddr(recAddr), .recData(recData),
    .frameErr(frameErr)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBits(input logic [23:0] mPat, input logic [23:0] sPat, input int nBits);
    for (int i = 0; i < nBits; i++) begin
      spiMosi = mPat[23-i];
      spiMiso = sPat[23-i];
      waitCyc(5);
      spiSclk = 1'b1;
      waitCyc(5);
      spiSclk = 1'b0;
    end
  endtask

  // driver: one framed transaction, expectation pushed to the scoreboard
  task automatic sendFrame(input logic [7:0] cmd, input logic [7:0] wrByte,
                           input logic [7:0] rdByte, input int nBits, input string tag);
    expItem_t e;
    e.tag = tag;
    e.err = (nBits < 16);
    e.rw = cmd[6];
    e.addr = cmd[5:0];
    e.data = cmd[6] ? wrByte : rdByte;
    spiCsN = 1'b0;
    waitCyc(8);
    clockBits({cmd, wrByte, 8'hC3}, {~cmd, rdByte, 8'h96}, nBits);
    waitCyc(6);
    expQ.push_back(e);
    spiCsN = 1'b1;
    csRiseCycle = cycle;
    waitCyc(12);
  endtask

  // traffic for another device: watched select stays high
  task automatic foreignTraffic(input logic [7:0] a, input logic [7:0] b);
    spiCsN = 1'b1;
    waitCyc(4);
    clockBits({a, b, 8'h00}, {b, a, 8'hFF}, 16);
    waitCyc(10);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rstN && !finished && (recValid || frameErr)) begin
      expItem_t e;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected output valid=%0b err=%0b, expected none", recValid, frameErr);
      end else begin
        e = expQ.pop_front();
        if (e.err) begin
          if (!frameErr || recValid) begin
            errors++;
            $display("FAIL %s: valid=%0b err=%0b, expected valid=0 err=1", e.tag, recValid, frameErr);
          end
        end else if (!recValid || frameErr || recRw != e.rw || recAddr != e.addr || recData != e.data) begin
          errors++;
          $display("FAIL %s: valid=%0b err=%0b rw=%0b addr=%h data=%h, expected valid=1 err=0 rw=%0b addr=%h data=%h",
                   e.tag, recValid, frameErr, recRw, recAddr, recData, e.rw, e.addr, e.data);
        end
        checks++;
        if (cycle - csRiseCycle > 4) begin
          errors++;
          $display("FAIL R8: latency %0d cycles, expected at most 4", cycle - csRiseCycle);
        end
      end
    end
  end

  task automatic finishRun();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    // R1: idle outputs after reset
    for (int k = 0; k < 3; k++) begin
      waitCyc(2);
      checks++;
      if (recValid || frameErr) begin
        errors++;
        $display("FAIL R1: valid=%0b err=%0b, expected 0 0", recValid, frameErr);
      end
    end
    sendFrame(8'h41, 8'h40, 8'h99, 16, "R2");   // write addr 1
    sendFrame(8'h01, 8'h77, 8'h40, 16, "R3");   // read addr 1, MOSI payload differs
    sendFrame(8'h7F, 8'hA5, 8'h5A, 16, "R2");   // write top address
    sendFrame(8'h00, 8'hFF, 8'h00, 16, "R3");   // read addr 0, data zero
    sendFrame(8'hC5, 8'h3E, 8'h11, 16, "R4");   // bit7 set, write
    sendFrame(8'h8A, 8'h22, 8'hE7, 16, "R4");   // bit7 set, read
    sendFrame(8'h40, 8'h01, 8'h80, 16, "R5");   // LSB-only write payload
    sendFrame(8'h20, 8'h80, 8'h01, 16, "R5");   // LSB-only read payload
    foreignTraffic(8'h7F, 8'hFF);
    foreignTraffic(8'h4A, 8'h0F);
    sendFrame(8'h13, 8'hF0, 8'h6C, 16, "R6");   // right after foreign traffic
    sendFrame(8'h55, 8'h12, 8'h34, 7,  "R7");   // short, inside command
    sendFrame(8'h55, 8'h12, 8'h34, 15, "R7");   // one bit short
    sendFrame(8'h55, 8'h12, 8'h34, 0,  "R7");   // no clocks at all
    sendFrame(8'h6E, 8'hB4, 8'h4B, 24, "R9");   // extra bits ignored
    sendFrame(8'h2D, 8'hB4, 8'hD2, 20, "R9");
    sendFrame(8'h7A, 8'h9C, 8'hC9, 16, "R8");   // normal after errors
    waitCyc(20);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R8: %0d records missing, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule